// File: doc/BRIEF.md
# Nine-to-Eighteen Bit Bus Width Matcher

This block joins a 9-bit narrow port to two 18-bit FIFO paths, one for each direction. On the inbound path it collects two consecutive 9-bit words and pushes them as one 18-bit word into the receiving FIFO. A holding register keeps the first word of each pair and raises a status bit while it is occupied. On the outbound path it hands the two 9-bit halves of the source FIFO's head word to the narrow port, one half per transfer. The source read pointer is stepped only once, after the second half has gone.

Each 9-bit word carries eight data bits and one parity bit. In the 18-bit word the two parity bits sit at the top, apart from their data bytes. A configuration bit chooses whether the lower or the upper half travels first on the narrow port. Every data path is a valid/ready stream. The FIFO fill state arrives as ready on the push side and as valid on the pop side. A transfer takes place in any cycle where valid and ready are both high. A source may not withdraw or change a word while its valid is high and no transfer has taken place. Back-pressure on the 18-bit push stalls the narrow input only while a half word is held. Back-pressure on the narrow output freezes the outbound half selection. The configuration bits are to be changed only when no pair is in progress.

Top module: `halfword_matcher`

## Requirements
- R1: An 18-bit word is split into two 9-bit halves. The lower half is data bits 7:0 with parity bit 16. The upper half is data bits 15:8 with parity bit 17. On the 9-bit side, bits 7:0 are data and bit 8 is parity.
- R2: When cfg_upper_first is 0, the first 9-bit word of each pair, in either direction, is the lower half. When it is 1, the first word is the upper half.
- R3: A write accepted on the narrow input while odd_valid is 0 is stored in the holding register and pushes nothing. odd_valid reads 1 from the next cycle on.
- R4: While odd_valid is 1, w_push_valid equals n_in_valid, and w_push_data joins the held word with the current input. wr_ptr_adv pulses in the cycle of the push handshake, and odd_valid reads 0 from the next cycle on.
- R5: n_in_ready equals (not odd_valid) or w_push_ready. While the push is refused, the held word and odd_valid are kept.
- R6: stat_byte shows bits 7:0 of the held word when cfg_stat_fmt is 0 and odd_valid is 1. Otherwise it is all zeros.
- R7: On the first half of a read pair, n_out_valid equals w_pop_valid and n_out_data is the first half of w_pop_data. The handshake captures the word and does not pulse rd_ptr_adv.
- R8: On the second half of a read pair, n_out_valid is 1 whatever w_pop_valid is, and n_out_data comes from the captured word. rd_ptr_adv pulses in that handshake cycle only, so it never pulses in two consecutive cycles.
- R9: rst_n low (asynchronous) or soft_reset high at a clock edge clears odd_valid and the read half selection, so the next access in each direction starts on the first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_reset | input | 1 | Synchronous reset-all of pair state |
| cfg_upper_first | input | 1 | 0: lower half first, 1: upper half first |
| cfg_stat_fmt | input | 1 | 0: mirror held byte on stat_byte, 1: zeros |
| n_in_valid | input | 1 | Narrow write word valid |
| n_in_ready | output | 1 | Narrow write word accepted |
| n_in_data | input | 9 | Narrow write word (bit 8 parity) |
| w_push_valid | output | 1 | 18-bit push request to receiving FIFO |
| w_push_ready | input | 1 | Receiving FIFO not full |
| w_push_data | output | 18 | Assembled 18-bit word |
| wr_ptr_adv | output | 1 | Receiving FIFO write-pointer advance pulse |
| w_pop_valid | input | 1 | Source FIFO not empty |
| w_pop_data | input | 18 | Source FIFO head word |
| rd_ptr_adv | output | 1 | Source FIFO read-pointer advance pulse |
| n_out_valid | output | 1 | Narrow read word valid |
| n_out_ready | input | 1 | Narrow read word taken |
| n_out_data | output | 9 | Narrow read word (bit 8 parity) |
| odd_valid | output | 1 | Holding register occupied |
| stat_byte | output | 8 | Status byte mirroring held data |

## Verification
Ready, push valid, push data, both pointer pulses, n_out_valid and n_out_data are combinational, so they are due in the same cycle as the inputs that cause them. odd_valid, stat_byte and the read half selection change only at the clock edge after a handshake or a soft_reset. The bench drives inputs on the falling edge and compares every output one nanosecond later against a reference model. It updates the model from the handshakes at the rising edge, so each state effect is checked exactly one cycle after its cause.

// File: rtl/hm_pkg.sv
package hm_pkg;
  // Which half of a pair is next on the outbound path
  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;

  // Status byte source
  typedef enum logic {
    STAT_MIRROR = 1'b0,
    STAT_BLANK  = 1'b1
  } stat_fmt_e;
endpackage

// File: rtl/hm_pack.sv
module hm_pack #(
  parameter int HALF_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_clr,
  input  logic                  upper_first,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [HALF_W-1:0]     in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*HALF_W-1:0]   out_data,
  output logic                  push,
  output logic                  held_valid,
  output logic [HALF_W-1:0]     held_data
);
  localparam int D = HALF_W - 1;

  logic              hv_q;
  logic [HALF_W-1:0] hold_q;
  logic [HALF_W-1:0] lo_h, hi_h;

  always_comb begin
    lo_h      = upper_first ? in_data : hold_q;
    hi_h      = upper_first ? hold_q  : in_data;
    out_data  = {hi_h[D], lo_h[D], hi_h[D-1:0], lo_h[D-1:0]};
    out_valid = hv_q & in_valid;
    in_ready  = ~hv_q | out_ready;
    push      = out_valid & out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q   <= 1'b0;
      hold_q <= '0;
    end else if (soft_clr) begin
      hv_q   <= 1'b0;
    end else if (in_valid && in_ready) begin
      if (!hv_q) begin
        hv_q   <= 1'b1;
        hold_q <= in_data;
      end else begin
        hv_q   <= 1'b0;
      end
    end
  end

  assign held_valid = hv_q;
  assign held_data  = hold_q;
endmodule

// File: rtl/hm_unpack.sv
module hm_unpack
  import hm_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_clr,
  input  logic                  upper_first,
  input  logic                  in_valid,
  input  logic [2*HALF_W-1:0]   in_data,
  output logic                  pop,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [HALF_W-1:0]     out_data
);
  localparam int D = HALF_W - 1;

  half_e               half_q;
  logic [2*HALF_W-1:0] word_q;
  logic [2*HALF_W-1:0] src;
  logic                take_upper;

  always_comb begin
    src        = (half_q == HALF_SECOND) ? word_q : in_data;
    take_upper = (half_q == HALF_SECOND) ^ upper_first;
    out_data   = take_upper ? {src[2*D+1], src[2*D-1:D]}
                            : {src[2*D],   src[D-1:0]};
    out_valid  = (half_q == HALF_SECOND) | in_valid;
    pop        = (half_q == HALF_SECOND) & out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_FIRST;
      word_q <= '0;
    end else if (soft_clr) begin
      half_q <= HALF_FIRST;
    end else if (out_valid && out_ready) begin
      if (half_q == HALF_FIRST) begin
        half_q <= HALF_SECOND;
        word_q <= in_data;
      end else begin
        half_q <= HALF_FIRST;
      end
    end
  end
endmodule

// File: rtl/hm_status.sv
module hm_status
  import hm_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  logic              fmt,
  input  logic              held_valid,
  input  logic [HALF_W-1:0] held_data,
  output logic [HALF_W-2:0] stat_byte
);
  always_comb begin
    if (fmt == STAT_MIRROR && held_valid) stat_byte = held_data[HALF_W-2:0];
    else                                  stat_byte = '0;
  end
endmodule

// File: rtl/halfword_matcher.sv
module halfword_matcher #(
  parameter int HALF_W = 9,
  localparam int WIDE_W = 2 * HALF_W,
  localparam int DATA_W = HALF_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_reset,
  input  logic              cfg_upper_first,
  input  logic              cfg_stat_fmt,
  input  logic              n_in_valid,
  output logic              n_in_ready,
  input  logic [HALF_W-1:0] n_in_data,
  output logic              w_push_valid,
  input  logic              w_push_ready,
  output logic [WIDE_W-1:0] w_push_data,
  output logic              wr_ptr_adv,
  input  logic              w_pop_valid,
  input  logic [WIDE_W-1:0] w_pop_data,
  output logic              rd_ptr_adv,
  output logic              n_out_valid,
  input  logic              n_out_ready,
  output logic [HALF_W-1:0] n_out_data,
  output logic              odd_valid,
  output logic [DATA_W-1:0] stat_byte
);
  logic [HALF_W-1:0] held_data;

  hm_pack #(.HALF_W(HALF_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_reset),
    .upper_first(cfg_upper_first),
    .in_valid   (n_in_valid),
    .in_ready   (n_in_ready),
    .in_data    (n_in_data),
    .out_valid  (w_push_valid),
    .out_ready  (w_push_ready),
    .out_data   (w_push_data),
    .push       (wr_ptr_adv),
    .held_valid (odd_valid),
    .held_data  (held_data)
  );

  hm_unpack #(.HALF_W(HALF_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_reset),
    .upper_first(cfg_upper_first),
    .in_valid   (w_pop_valid),
    .in_data    (w_pop_data),
    .pop        (rd_ptr_adv),
    .out_valid  (n_out_valid),
    .out_ready  (n_out_ready),
    .out_data   (n_out_data)
  );

  hm_status #(.HALF_W(HALF_W)) u_status (
    .fmt        (cfg_stat_fmt),
    .held_valid (odd_valid),
    .held_data  (held_data),
    .stat_byte  (stat_byte)
  );
endmodule

// File: rtl/halfword_matcher_chk.sv
module halfword_matcher_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_reset,
  input logic n_in_valid,
  input logic n_in_ready,
  input logic w_push_valid,
  input logic w_push_ready,
  input logic rd_ptr_adv,
  input logic n_out_valid,
  input logic n_out_ready,
  input logic odd_valid
);
  // R3: holder fills only after an accepted narrow write
  assert_hold_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(odd_valid) |-> $past(n_in_valid && n_in_ready && !soft_reset));

  // R4: a push is requested only while a half word is held
  assert_push_needs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w_push_valid |-> odd_valid);

  // R5: a refused push keeps the held word
  assert_stall_keeps_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_push_valid && !w_push_ready && !soft_reset) |=> odd_valid);

  // R8: read pointer steps only on a real narrow transfer, never twice in a row
  assert_rdadv_on_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_adv |-> (n_out_valid && n_out_ready));
  assert_rdadv_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_adv |=> !rd_ptr_adv);

  // R9: soft reset empties the holder
  assert_soft_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !odd_valid);
endmodule

bind halfword_matcher halfword_matcher_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_reset  (soft_reset),
  .n_in_valid  (n_in_valid),
  .n_in_ready  (n_in_ready),
  .w_push_valid(w_push_valid),
  .w_push_ready(w_push_ready),
  .rd_ptr_adv  (rd_ptr_adv),
  .n_out_valid (n_out_valid),
  .n_out_ready (n_out_ready),
  .odd_valid   (odd_valid)
);

// File: tb/sim_halfword_matcher.sv
`timescale 1ns/1ps
module sim_halfword_matcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_reset = 1'b0, cfg_upper_first = 1'b0, cfg_stat_fmt = 1'b0;
  logic n_in_valid = 1'b0, w_push_ready = 1'b0, w_pop_valid = 1'b0, n_out_ready = 1'b0;
  logic [8:0]  n_in_data = '0;
  logic [17:0] w_pop_data = '0;
  logic n_in_ready, w_push_valid, wr_ptr_adv, rd_ptr_adv, n_out_valid, odd_valid;
  logic [17:0] w_push_data;
  logic [8:0]  n_out_data;
  logic [7:0]  stat_byte;

  always #2.5 clk = ~clk;

  halfword_matcher u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  bit        m_hv = 0, m_half = 0;
  logic [8:0]  m_hold = '0;
  logic [17:0] m_rdw = '0;

  function automatic logic [17:0] join_w(input logic [8:0] lo, input logic [8:0] hi);
    logic [17:0] w;
    w[7:0] = lo[7:0]; w[15:8] = hi[7:0]; w[16] = lo[8]; w[17] = hi[8];
    return w;
  endfunction

  function automatic logic [8:0] pick(input logic [17:0] w, input bit upper);
    return upper ? {w[17], w[15:8]} : {w[16], w[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, compare 1ns later, update model at posedge
  task automatic step(input bit iv, input logic [8:0] id, input bit pr,
                      input bit pv, input logic [17:0] pd, input bit orr, input bit sr);
    bit e_ir, e_pv, e_wa, e_ov, e_ra;
    logic [17:0] e_pd; logic [8:0] e_od; logic [7:0] e_sb;
    n_in_valid = iv; n_in_data = id; w_push_ready = pr;
    w_pop_valid = pv; w_pop_data = pd; n_out_ready = orr; soft_reset = sr;
    #1;
    e_ir = !m_hv || pr;
    e_pv = m_hv && iv;
    e_pd = cfg_upper_first ? join_w(id, m_hold) : join_w(m_hold, id);
    e_wa = e_pv && pr;
    e_sb = (cfg_stat_fmt == 1'b0 && m_hv) ? m_hold[7:0] : 8'h00;
    e_ov = m_half ? 1'b1 : pv;
    e_od = m_half ? pick(m_rdw, !cfg_upper_first) : pick(pd, cfg_upper_first);
    e_ra = m_half && orr;
    chk(n_in_ready == e_ir, "R5", 18'(n_in_ready), 18'(e_ir));
    chk(w_push_valid == e_pv, "R4", 18'(w_push_valid), 18'(e_pv));
    if (e_pv) chk(w_push_data == e_pd, "R1/R2 push data", w_push_data, e_pd);
    chk(wr_ptr_adv == e_wa, "R4 wr_ptr_adv", 18'(wr_ptr_adv), 18'(e_wa));
    chk(odd_valid == m_hv, "R3", 18'(odd_valid), 18'(m_hv));
    chk(stat_byte == e_sb, "R6", 18'(stat_byte), 18'(e_sb));
    chk(n_out_valid == e_ov, m_half ? "R8 valid" : "R7 valid", 18'(n_out_valid), 18'(e_ov));
    if (e_ov) chk(n_out_data == e_od, m_half ? "R8 data" : "R7 data", 18'(n_out_data), 18'(e_od));
    chk(rd_ptr_adv == e_ra, "R8 rd_ptr_adv", 18'(rd_ptr_adv), 18'(e_ra));
    @(posedge clk);
    if (sr) begin
      m_hv = 0; m_half = 0;
    end else begin
      if (iv && e_ir) begin
        if (!m_hv) begin m_hv = 1; m_hold = id; end else m_hv = 0;
      end
      if (e_ov && orr) begin
        if (!m_half) begin m_half = 1; m_rdw = pd; end else m_half = 0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R9
    #1;
    chk(odd_valid == 1'b0, "R9 reset odd_valid", 18'(odd_valid), 18'd0);
    chk(stat_byte == 8'h00, "R9 reset stat_byte", 18'(stat_byte), 18'd0);
    @(negedge clk);

    // R2 lower first: write 0x1A5 then 0x03C, push ready
    cfg_upper_first = 0;
    step(1, 9'h1A5, 1, 0, '0, 0, 0);
    step(1, 9'h03C, 1, 0, '0, 0, 0);
    // R2 upper first
    cfg_upper_first = 1;
    step(1, 9'h0F0, 1, 0, '0, 0, 0);
    step(1, 9'h10F, 1, 0, '0, 0, 0);
    // R5 stall with FIFO full, held word kept
    step(1, 9'h155, 0, 0, '0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 9'h0AA, 0, 0, '0, 0, 0);
    step(1, 9'h0AA, 1, 0, '0, 0, 0);
    // R6 blank format
    cfg_stat_fmt = 1;
    step(1, 9'h077, 0, 0, '0, 0, 0);
    step(0, 9'h000, 0, 0, '0, 0, 0);
    cfg_stat_fmt = 0;
    step(0, 9'h000, 0, 0, '0, 0, 0);
    // R9 soft reset mid pair (write and read)
    step(0, 9'h000, 0, 1, 18'h2_5A3C, 1, 0);
    step(0, 9'h000, 0, 0, 18'h0, 0, 1);
    // R7/R8 reads, second half with source empty
    cfg_upper_first = 0;
    step(0, 9'h000, 0, 1, 18'h1_C3B4, 1, 0);
    step(0, 9'h000, 0, 0, 18'h0, 0, 0);
    step(0, 9'h000, 0, 0, 18'h0, 1, 0);
    step(0, 9'h000, 0, 0, 18'h0, 1, 0);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if (!m_hv && !m_half && ($urandom % 16) == 0) begin
        cfg_upper_first = $urandom % 2;
        cfg_stat_fmt    = $urandom % 2;
      end
      step($urandom % 4 != 0, 9'($urandom), $urandom % 3 != 0,
           $urandom % 4 != 0, 18'($urandom), $urandom % 3 != 0,
           ($urandom % 97) == 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule